// File: doc/BRIEF.md
# Power-Up Instruction Admission Gate

This block sits between the serial command decoder of a nonvolatile memory and the memory's internal controller. It decides whether each decoded instruction may take effect while the supply is ramping up and after it has settled. Two digital supply flags drive it. The first says the supply is above the power-on-reset threshold. The second says it is above the minimum operating level. While the first flag is low the block does nothing, and every instruction passes without effect.

Two cycle-count timers measure the power-up delays. The threshold timer runs for `TPUW` cycles from the threshold crossing. The operating-level timer runs for `TVSL` cycles from the moment the supply reaches operating level. A read-class instruction needs only the operating-level delay to have run out. A write-class instruction also needs the threshold delay to have run out. Each strobed instruction gets a registered verdict one clock later: an accept pulse or a reject pulse. The controller uses `status_clr_o` to hold its write-enable latch and write-in-progress bits at zero until power-up is complete. `standby_o` tells it that the device is powered and idle.

Top module: `pwrup_cmd_gate`

## Requirements
- R1: While `rst_ni` is low, or in every cycle that follows a clock edge at which `por_ok_i` was low, `cmd_accept_o`, `cmd_reject_o`, `cmd_wr_o` and `standby_o` are 0 and `status_clr_o` is 1.
- R2: An opcode is write-class exactly when it equals one entry of `WR_OP_LIST`. The default list is 8'h06, 8'h02, 8'hA2, 8'hD8, 8'hC7 and 8'h01. Every other opcode is read-class. `cmd_wr_o` is 1 together with `cmd_accept_o` exactly when the accepted opcode is write-class.
- R3: A read-class instruction is accepted only when `vmin_ok_i`, with `por_ok_i` also high, has been sampled high on at least `TVSL` consecutive clock edges before the strobe edge.
- R4: A write-class instruction is accepted only when the R3 condition holds and `por_ok_i` has also been sampled high on at least `TPUW` consecutive edges before the strobe edge.
- R5: An instruction that is strobed while `por_ok_i` is high and is not accepted produces a one-cycle `cmd_reject_o` pulse, with `cmd_accept_o` held at 0. Accept and reject are never high together.
- R6: Exactly one verdict comes for each strobe taken while `por_ok_i` is high. The verdict is registered and appears in the cycle after the strobe edge. With no strobe, neither verdict output rises.
- R7: If a supply flag is sampled low before its timer has expired, that timer starts again from zero. The full delay must then pass again after the flag returns high.
- R8: A low sample of `por_ok_i` clears both timers at once. No verdict is given for any instruction until a new power-up sequence has completed.
- R9: `status_clr_o` is 1 until the operating-level delay has expired. After that, `standby_o` is 1 in every cycle where `cmd_accept_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| por_ok_i | input | 1 | Supply above power-on-reset threshold (synchronous) |
| vmin_ok_i | input | 1 | Supply above minimum operating level (synchronous) |
| cmd_valid_i | input | 1 | Decoded instruction strobe |
| cmd_op_i | input | 8 | Decoded opcode |
| cmd_accept_o | output | 1 | Instruction accepted, one cycle after the strobe |
| cmd_reject_o | output | 1 | Instruction ignored, one cycle after the strobe |
| cmd_wr_o | output | 1 | The accepted instruction is write-class |
| status_clr_o | output | 1 | Hold the write-enable and write-in-progress bits cleared |
| standby_o | output | 1 | Powered up and idle |

## Verification
The bench targets the window between the two delays. There, reads must pass and writes must be refused. A gate that used a single ready flag would either refuse the reads or let the writes through. It also drops a supply flag a cycle or two before a timer expires. A timer that paused instead of restarting would grant access early. Collapses of the threshold flag during traffic check that the verdicts stop at once and that both delays start over. The bench also strobes on the exact edge where a timer expires, which exposes an off-by-one count. It drives every listed write opcode as well as near-miss values, which catches a wrong or truncated opcode comparison.

// File: rtl/pwrup_gate_pkg.sv
package pwrup_gate_pkg;
  typedef logic [7:0] opcode_t;

  localparam int unsigned N_WR_OPS_DEF = 6;
  // write enable, page program, dual-in program, sector erase, bulk erase, status write
  localparam logic [N_WR_OPS_DEF*8-1:0] WR_OP_LIST_DEF =
    {8'h01, 8'hC7, 8'hD8, 8'hA2, 8'h02, 8'h06};
endpackage

// File: rtl/pwrup_delay_timer.sv
module pwrup_delay_timer #(
  parameter int unsigned CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CW = (CYCLES < 1) ? 1 : $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(CYCLES);

  logic [CW-1:0] cnt_q;

  // clears on any low sample of run_i, saturates at LIMIT
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!run_i)         cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == LIMIT);
endmodule

// File: rtl/pwrup_op_class.sv
module pwrup_op_class
  import pwrup_gate_pkg::*;
#(
  parameter int unsigned           N_WR_OPS   = N_WR_OPS_DEF,
  parameter logic [N_WR_OPS*8-1:0] WR_OP_LIST = WR_OP_LIST_DEF
) (
  input  opcode_t op_i,
  output logic    wr_class_o
);
  logic [N_WR_OPS-1:0] hit;

  for (genvar g = 0; g < N_WR_OPS; g++) begin : g_cmp
    assign hit[g] = (op_i == WR_OP_LIST[g*8 +: 8]);
  end

  assign wr_class_o = |hit;
endmodule

// File: rtl/pwrup_cmd_decide.sv
module pwrup_cmd_decide (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic por_ok_i,
  input  logic valid_i,
  input  logic wr_class_i,
  input  logic rd_ok_i,
  input  logic wr_ok_i,
  output logic accept_o,
  output logic reject_o,
  output logic wr_o
);
  logic grant;
  assign grant = wr_class_i ? (wr_ok_i && rd_ok_i) : rd_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_o <= 1'b0;
      reject_o <= 1'b0;
      wr_o     <= 1'b0;
    end else if (!por_ok_i) begin
      // below threshold: no response at all
      accept_o <= 1'b0;
      reject_o <= 1'b0;
      wr_o     <= 1'b0;
    end else begin
      accept_o <= valid_i && grant;
      reject_o <= valid_i && !grant;
      wr_o     <= valid_i && grant && wr_class_i;
    end
  end
endmodule

// File: rtl/pwrup_cmd_gate.sv
module pwrup_cmd_gate
  import pwrup_gate_pkg::*;
#(
  parameter int unsigned           TPUW       = 1000,
  parameter int unsigned           TVSL       = 300,
  parameter int unsigned           N_WR_OPS   = N_WR_OPS_DEF,
  parameter logic [N_WR_OPS*8-1:0] WR_OP_LIST = WR_OP_LIST_DEF
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       por_ok_i,
  input  logic       vmin_ok_i,
  input  logic       cmd_valid_i,
  input  logic [7:0] cmd_op_i,
  output logic       cmd_accept_o,
  output logic       cmd_reject_o,
  output logic       cmd_wr_o,
  output logic       status_clr_o,
  output logic       standby_o
);
  logic puw_done, vsl_done, wr_class, vsl_run;

  assign vsl_run = por_ok_i && vmin_ok_i;

  pwrup_delay_timer #(.CYCLES(TPUW)) u_puw_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(por_ok_i), .done_o(puw_done)
  );

  pwrup_delay_timer #(.CYCLES(TVSL)) u_vsl_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(vsl_run), .done_o(vsl_done)
  );

  pwrup_op_class #(.N_WR_OPS(N_WR_OPS), .WR_OP_LIST(WR_OP_LIST)) u_class (
    .op_i(cmd_op_i), .wr_class_o(wr_class)
  );

  pwrup_cmd_decide u_decide (
    .clk_i(clk_i), .rst_ni(rst_ni), .por_ok_i(por_ok_i),
    .valid_i(cmd_valid_i), .wr_class_i(wr_class),
    .rd_ok_i(vsl_done), .wr_ok_i(puw_done),
    .accept_o(cmd_accept_o), .reject_o(cmd_reject_o), .wr_o(cmd_wr_o)
  );

  assign status_clr_o = !vsl_done;
  assign standby_o    = vsl_done && !cmd_accept_o;
endmodule

// File: rtl/pwrup_cmd_gate_chk.sv
module pwrup_cmd_gate_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic por_ok_i,
  input logic cmd_valid_i,
  input logic wr_class,
  input logic puw_done,
  input logic vsl_done,
  input logic cmd_accept_o,
  input logic cmd_reject_o,
  input logic cmd_wr_o,
  input logic status_clr_o
);
  AST_CLR_BELOW_POR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !por_ok_i |=> status_clr_o && !cmd_wr_o); // R1
  AST_WR_FLAG_SUBSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr_o |-> cmd_accept_o); // R2
  AST_RD_NEEDS_VSL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && !vsl_done |=> !cmd_accept_o); // R3
  AST_WR_NEEDS_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && wr_class && !puw_done |=> !cmd_accept_o); // R4
  AST_VERDICT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_accept_o && cmd_reject_o)); // R5
  AST_ONE_VERDICT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && por_ok_i |=> cmd_accept_o || cmd_reject_o); // R6
  AST_NO_STROBE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> !cmd_accept_o && !cmd_reject_o); // R6
  AST_SILENT_BELOW_POR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !por_ok_i |=> !cmd_accept_o && !cmd_reject_o && !puw_done); // R8
endmodule

bind pwrup_cmd_gate pwrup_cmd_gate_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .por_ok_i(por_ok_i), .cmd_valid_i(cmd_valid_i),
  .wr_class(wr_class), .puw_done(puw_done), .vsl_done(vsl_done),
  .cmd_accept_o(cmd_accept_o), .cmd_reject_o(cmd_reject_o), .cmd_wr_o(cmd_wr_o),
  .status_clr_o(status_clr_o)
);

// File: tb/pwrup_cmd_gate_test.sv
module pwrup_cmd_gate_test;
  import pwrup_gate_pkg::*;
  localparam int TPUW = 40;
  localparam int TVSL = 12;

  logic clk = 1'b0, rst_n = 1'b0, por = 1'b0, vmin = 1'b0, valid = 1'b0;
  logic [7:0] op = 8'h00;
  logic acc, rej, wr, clr, stb;

  int checks = 0, errors = 0;
  int puw_c = 0, vsl_c = 0;
  logic e_acc = 1'b0, e_rej = 1'b0, e_wr = 1'b0, e_clr = 1'b1, e_stb = 1'b0;
  string e_tag = "R1";
  bit finished = 0;

  pwrup_cmd_gate #(.TPUW(TPUW), .TVSL(TVSL)) uut (
    .clk_i(clk), .rst_ni(rst_n), .por_ok_i(por), .vmin_ok_i(vmin),
    .cmd_valid_i(valid), .cmd_op_i(op), .cmd_accept_o(acc), .cmd_reject_o(rej),
    .cmd_wr_o(wr), .status_clr_o(clr), .standby_o(stb)
  );

  always #5 clk = ~clk;

  function automatic bit is_wr_op(logic [7:0] o);
    for (int i = 0; i < int'(N_WR_OPS_DEF); i++)
      if (o == WR_OP_LIST_DEF[i*8 +: 8]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // reference model, evaluated on the pre-edge state
  always @(posedge clk) begin
    if (!rst_n) begin
      puw_c = 0; vsl_c = 0;
      e_acc = 0; e_rej = 0; e_wr = 0;
    end else begin
      bit w, ok;
      w  = is_wr_op(op);
      ok = w ? (puw_c >= TPUW && vsl_c >= TVSL) : (vsl_c >= TVSL);
      e_acc = por && valid && ok;
      e_rej = por && valid && !ok;
      e_wr  = e_acc && w;
      e_tag = !por ? "R8" : (w ? "R4" : "R3");
      puw_c = por ? ((puw_c < TPUW) ? puw_c + 1 : puw_c) : 0;
      vsl_c = (por && vmin) ? ((vsl_c < TVSL) ? vsl_c + 1 : vsl_c) : 0;
    end
    e_clr = !(vsl_c >= TVSL);
    e_stb = !e_clr && !e_acc;
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(acc == e_acc, e_tag, "accept (R6 timing)", int'(acc), int'(e_acc));
      chk(rej == e_rej, "R5", "reject", int'(rej), int'(e_rej));
      chk(wr == e_wr, "R2", "write-class flag", int'(wr), int'(e_wr));
      chk(clr == e_clr, "R9", "status clear", int'(clr), int'(e_clr));
      chk(stb == e_stb, "R9", "standby", int'(stb), int'(e_stb));
    end
  end

  task automatic tick(int n, int strobe_pct);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid = ($urandom_range(99) < strobe_pct);
      op = ($urandom_range(1) == 0) ? WR_OP_LIST_DEF[$urandom_range(N_WR_OPS_DEF-1)*8 +: 8]
                                    : 8'($urandom_range(255));
    end
  endtask

  task automatic send(logic [7:0] o);
    @(negedge clk);
    valid = 1'b1; op = o;
    @(negedge clk);
    valid = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(acc == 0 && rej == 0 && wr == 0, "R1", "verdicts in reset", int'(acc | rej | wr), 0);
    chk(clr == 1 && stb == 0, "R1", "status in reset", int'(clr), 1);
    rst_n = 1'b1;
    // R8: strobes below threshold get no verdict
    tick(10, 80);
    // directed: vmin rises with por; window between the delays (R3 vs R4)
    @(negedge clk); por = 1'b1; vmin = 1'b1;
    tick(TVSL + 2, 60);
    tick(TPUW - TVSL - 4, 80);
    tick(6, 100); // strobes across the TPUW expiry edge
    // R2: every listed opcode and near misses
    for (int i = 0; i < int'(N_WR_OPS_DEF); i++) send(WR_OP_LIST_DEF[i*8 +: 8]);
    send(8'h03); send(8'h07); send(8'hD9); send(8'h00); send(8'hC6);
    // R7: vmin glitch just before its timer expires
    @(negedge clk); vmin = 1'b0;
    @(negedge clk); vmin = 1'b1;
    tick(TVSL - 2, 100);
    @(negedge clk); vmin = 1'b0;
    @(negedge clk); vmin = 1'b1;
    tick(TVSL + 3, 100);
    // R8: threshold collapse mid-traffic, then por glitch before TPUW
    @(negedge clk); por = 1'b0;
    tick(5, 100);
    @(negedge clk); por = 1'b1;
    tick(TPUW - 3, 50);
    @(negedge clk); por = 1'b0;
    @(negedge clk); por = 1'b1;
    tick(TPUW + 5, 50);
    // constrained random power sequences
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); por = 1'b0; vmin = 1'b0;
      tick($urandom_range(6, 1), 50);
      @(negedge clk); por = 1'b1;
      tick($urandom_range(60), 50);
      @(negedge clk); vmin = 1'b1;
      for (int j = 0; j < 120; j++) begin
        tick(1, 50);
        if ($urandom_range(63) == 0) vmin = ~vmin;
        if ($urandom_range(199) == 0) por = 1'b0;
        else if (!por && $urandom_range(3) == 0) por = 1'b1;
      end
    end
    @(negedge clk); valid = 1'b0;
    @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule